// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Function Select

This block is a memory-mapped general-purpose I/O controller for 54 pins on a simple 32-bit register bus. The bus carries a word address, a write enable, write data and read data. The read data is registered, so a word addressed in one cycle appears on the read port in the next cycle.

Each pin has a 3-bit function field. The field selects input, output or one of six alternate functions. The alternate functions use a non-sequential encoding, and the block decodes it into a per-pin alternate enable and an alternate index for the peripheral mux outside this block. Output values are held in a per-pin latch. Software changes the latch through separate write-one-to-set and write-one-to-clear words, so no read-modify-write cycle is needed. The pad inputs are synchronised and read back through two level words, one for each bank of 32 pins.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all function fields are 0 (input), all output latches are 0, every `pad_oe_o` bit is 0 and `rdata_o` is 0.
- R2: Pin n owns bits (n mod 10)*3+2..(n mod 10)*3 of select word n/10, at word addresses 0..5. Reading a select word returns the fields that were written for existing pins. Bits 30 and 31, and the bits of word 5 above pin 53's field (bits 12..31), read as 0.
- R3: `mode_o[3n+2:3n]` carries pin n's function field at all times.
- R4: A write to set word 7 (bank 0: pins 0..31, bit n) or set word 8 (bank 1: pins 32..53, bit n-32) drives each latch whose bit is 1 high. Latches whose bit is 0 keep their value.
- R5: A write to clear word 10 (bank 0) or clear word 11 (bank 1) drives each latch whose bit is 1 low. Latches whose bit is 0 keep their value.
- R6: `pad_oe_o[n]` is 1 only when pin n's field is 1 (output). `pad_o[n]` equals the latch when enabled and is 0 otherwise.
- R7: Level word 13 returns pads 0..31 and level word 14 returns pads 32..53 in bits 0..21, with the upper bits 0. Each pad passes through two synchroniser flops, so a pad change appears in read data captured at the third rising edge after the change.
- R8: The set and clear words, the reserved words 6, 9 and 12, and all addresses 15 and above read as 0. Writes to the reserved and unmapped words change no state.
- R9: Read data is captured at the clock edge after the address is presented. When a write and a read hit the same word in the same cycle, the read returns the contents from before the write.
- R10: For every pin not in input or output mode, `alt_en_o[n]` is 1 and `alt_idx_o[3n+2:3n]` gives the alternate number: field 4->0, 5->1, 6->2, 7->3, 3->4, 2->5. For fields 0 and 1, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_i | input | 54 | Pad input levels (asynchronous) |
| pad_o | output | 54 | Pad output values |
| pad_oe_o | output | 54 | Pad output enables |
| mode_o | output | 162 | Per-pin function field, pin n at bits 3n+2..3n |
| alt_en_o | output | 54 | Per-pin alternate function active |
| alt_idx_o | output | 162 | Per-pin alternate number, pin n at bits 3n+2..3n |

## Verification
The only collision on this bus is a read and a write of the same word in one cycle, because the read port samples the address on every edge. The bench provokes this on a select word by raising the write enable while the address is held on that word. It then requires the captured read data to equal the old contents, and a later plain read to return the new contents. Pad synchronisation is a second point where timing matters: the bench changes a pad and reads the level word at the first, second and third edges after the change, and the value must change only at the third.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned FIELD_W  = 3;
  localparam int unsigned FIELDS_PER_WORD = 10;

  // word map; neighbours decode these offsets
  localparam int unsigned SEL_BASE = 0;
  localparam int unsigned SET_BASE = 7;
  localparam int unsigned CLR_BASE = 10;
  localparam int unsigned LVL_BASE = 13;

  typedef enum logic [FIELD_W-1:0] {
    FN_INPUT  = 3'd0,
    FN_OUTPUT = 3'd1,
    FN_ALT5   = 3'd2,
    FN_ALT4   = 3'd3,
    FN_ALT0   = 3'd4,
    FN_ALT1   = 3'd5,
    FN_ALT2   = 3'd6,
    FN_ALT3   = 3'd7
  } pin_fn_e;

  function automatic logic [FIELD_W-1:0] alt_number(input logic [FIELD_W-1:0] f);
    case (pin_fn_e'(f))
      FN_ALT0: alt_number = 3'd0;
      FN_ALT1: alt_number = 3'd1;
      FN_ALT2: alt_number = 3'd2;
      FN_ALT3: alt_number = 3'd3;
      FN_ALT4: alt_number = 3'd4;
      FN_ALT5: alt_number = 3'd5;
      default: alt_number = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_fn_regs.sv
module gpio_fn_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           wr_word_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [ADDR_W-1:0]           rd_word_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [NUM_PINS*FIELD_W-1:0] mode_o
);

  localparam int unsigned LAST_PIN  = NUM_PINS - 1;
  localparam int unsigned LAST_WORD = LAST_PIN / FIELDS_PER_WORD;
  localparam int unsigned LAST_OFF  = (LAST_PIN % FIELDS_PER_WORD) * FIELD_W;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int unsigned WORD = n / FIELDS_PER_WORD;
    localparam int unsigned OFF  = (n % FIELDS_PER_WORD) * FIELD_W;
    logic [FIELD_W-1:0] fn_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   fn_q <= FN_INPUT;
      else if (wr_i && wr_word_i == ADDR_W'(WORD))   fn_q <= wdata_i[OFF +: FIELD_W];
    end

    assign mode_o[n*FIELD_W +: FIELD_W] = fn_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (rd_word_i == ADDR_W'(n / FIELDS_PER_WORD))
        rd_data_o[(n % FIELDS_PER_WORD)*FIELD_W +: FIELD_W] = mode_o[n*FIELD_W +: FIELD_W];
    end
  end

  // R2
  first_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_word_i == '0) |=> mode_o[FIELD_W-1:0] == $past(wdata_i[FIELD_W-1:0]));

  // R2
  last_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_word_i == ADDR_W'(LAST_WORD))
      |=> mode_o[LAST_PIN*FIELD_W +: FIELD_W] == $past(wdata_i[LAST_OFF +: FIELD_W]));

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_we_i,
  input  logic                clr_we_i,
  input  logic [ADDR_W-1:0]   bank_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] latch_o
);

  logic [NUM_PINS-1:0] hit_mask;

  always_comb begin
    hit_mask = '0;
    for (int n = 0; n < NUM_PINS; n++)
      if (bank_i == ADDR_W'(n / DATA_W)) hit_mask[n] = wdata_i[n % DATA_W];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      latch_o[n] <= 1'b0;
      else if (set_we_i && hit_mask[n]) latch_o[n] <= 1'b1;
      else if (clr_we_i && hit_mask[n]) latch_o[n] <= 1'b0;
    end
  end

  // R4
  set_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> (latch_o & $past(hit_mask)) == $past(hit_mask));

  // R4
  set_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> (latch_o & ~$past(hit_mask)) == ($past(latch_o) & ~$past(hit_mask)));

  // R5
  clr_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> (latch_o & $past(hit_mask)) == '0);

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 54
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] level_o
);

  logic [NUM_PINS-1:0] meta_q;
  logic [1:0]          warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= '0;
      level_o <= '0;
    end else begin
      meta_q  <= pad_i;
      level_o <= meta_q;
    end
  end

  // assertion support: cycles since reset, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> level_o == $past(pad_i, 2));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [NUM_PINS-1:0]         pad_i,
  output logic [NUM_PINS-1:0]         pad_o,
  output logic [NUM_PINS-1:0]         pad_oe_o,
  output logic [NUM_PINS*FIELD_W-1:0] mode_o,
  output logic [NUM_PINS-1:0]         alt_en_o,
  output logic [NUM_PINS*FIELD_W-1:0] alt_idx_o
);

  localparam int unsigned SEL_WORDS = (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int unsigned BANKS     = (NUM_PINS + DATA_W - 1) / DATA_W;

  logic                sel_hit, set_hit, clr_hit, lvl_hit;
  logic [ADDR_W-1:0]   sel_word, set_bank, clr_bank, lvl_bank, latch_bank;
  logic [DATA_W-1:0]   sel_rd, lvl_rd, rd_next;
  logic [NUM_PINS-1:0] latch_q, level_q;

  assign sel_word = addr_i - ADDR_W'(SEL_BASE);
  assign set_bank = addr_i - ADDR_W'(SET_BASE);
  assign clr_bank = addr_i - ADDR_W'(CLR_BASE);
  assign lvl_bank = addr_i - ADDR_W'(LVL_BASE);

  assign sel_hit = (addr_i >= ADDR_W'(SEL_BASE)) && (addr_i < ADDR_W'(SEL_BASE + SEL_WORDS));
  assign set_hit = (addr_i >= ADDR_W'(SET_BASE)) && (addr_i < ADDR_W'(SET_BASE + BANKS));
  assign clr_hit = (addr_i >= ADDR_W'(CLR_BASE)) && (addr_i < ADDR_W'(CLR_BASE + BANKS));
  assign lvl_hit = (addr_i >= ADDR_W'(LVL_BASE)) && (addr_i < ADDR_W'(LVL_BASE + BANKS));

  assign latch_bank = set_hit ? set_bank : clr_bank;

  gpio_fn_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_fn_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (we_i && sel_hit),
    .wr_word_i (sel_word),
    .wdata_i   (wdata_i),
    .rd_word_i (sel_word),
    .rd_data_o (sel_rd),
    .mode_o    (mode_o)
  );

  gpio_out_latch #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_out_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (we_i && set_hit),
    .clr_we_i (we_i && clr_hit),
    .bank_i   (latch_bank),
    .wdata_i  (wdata_i),
    .latch_o  (latch_q)
  );

  gpio_in_sync #(
    .NUM_PINS (NUM_PINS)
  ) u_in_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pad_i   (pad_i),
    .level_o (level_q)
  );

  always_comb begin
    lvl_rd = '0;
    for (int n = 0; n < NUM_PINS; n++)
      if (lvl_bank == ADDR_W'(n / DATA_W)) lvl_rd[n % DATA_W] = level_q[n];
  end

  always_comb begin
    if (sel_hit)      rd_next = sel_rd;
    else if (lvl_hit) rd_next = lvl_rd;
    else              rd_next = '0;
  end

  // read samples pre-write state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
    logic [FIELD_W-1:0] fn;
    assign fn           = mode_o[n*FIELD_W +: FIELD_W];
    assign pad_oe_o[n]  = (fn == FN_OUTPUT);
    assign pad_o[n]     = pad_oe_o[n] & latch_q[n];
    assign alt_en_o[n]  = (fn != FN_INPUT) && (fn != FN_OUTPUT);
    assign alt_idx_o[n*FIELD_W +: FIELD_W] = alt_number(fn);
  end

  // R8
  zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_hit && !lvl_hit) |=> rdata_o == '0);

  // R6
  pad_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & ~latch_q) == '0);

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, alt_en;
  logic [NP*3-1:0] mode, alt_idx;

  int n_chk = 0;
  int n_bad = 0;

  logic [2:0]    fn_exp [NP];
  logic [NP-1:0] lat_exp = '0;

  always #10 clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .mode_o(mode), .alt_en_o(alt_en), .alt_idx_o(alt_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 5'(a); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); addr = 5'(a); we = 1'b0;
    @(negedge clk); v = rdata;
  endtask

  function automatic logic [31:0] sel_exp(input int w);
    logic [31:0] r = '0;
    for (int n = 0; n < NP; n++) if (n / 10 == w) r[(n % 10)*3 +: 3] = fn_exp[n];
    return r;
  endfunction

  function automatic logic [2:0] alt_exp(input logic [2:0] f);
    case (f)
      3'd4: return 3'd0;  3'd5: return 3'd1;  3'd6: return 3'd2;
      3'd7: return 3'd3;  3'd3: return 3'd4;  3'd2: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  task automatic apply_lat(input bit is_set, input int bank, input logic [31:0] d);
    for (int n = 0; n < NP; n++)
      if (n / 32 == bank && d[n % 32]) lat_exp[n] = is_set;
  endtask

  task automatic check_pins(input string req);
    logic [NP-1:0] oe_e, po_e, ae_e;
    logic [NP*3-1:0] m_e, ai_e;
    for (int n = 0; n < NP; n++) begin
      oe_e[n] = (fn_exp[n] == 3'd1);
      po_e[n] = oe_e[n] & lat_exp[n];
      ae_e[n] = (fn_exp[n] > 3'd1);
      m_e[n*3 +: 3]  = fn_exp[n];
      ai_e[n*3 +: 3] = alt_exp(fn_exp[n]);
    end
    chk(mode == m_e, {req, " R3 mode"}, mode[63:0], m_e[63:0]);
    chk(pad_oe == oe_e, {req, " R6 oe"}, 64'(pad_oe), 64'(oe_e));
    chk(pad_out == po_e, {req, " R6 pad"}, 64'(pad_out), 64'(po_e));
    chk(alt_en == ae_e, {req, " R10 alt_en"}, 64'(alt_en), 64'(ae_e));
    chk(alt_idx == ai_e, {req, " R10 alt_idx"}, alt_idx[63:0], ai_e[63:0]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rdata == '0, "R1 rdata", 64'(rdata), 0);
    for (int n = 0; n < NP; n++) fn_exp[n] = 3'd0;
    check_pins("R1");
  endtask

  task automatic t_fields();
    logic [31:0] v;
    for (int w = 0; w < 6; w++) begin
      logic [31:0] d = 32'hC000_0000;
      for (int k = 0; k < 10; k++) d[k*3 +: 3] = 3'((w*10 + k)*3 + 1);
      wr(w, d);
      for (int k = 0; k < 10; k++) if (w*10 + k < NP) fn_exp[w*10 + k] = d[k*3 +: 3];
    end
    for (int w = 0; w < 6; w++) begin
      rd(w, v);
      chk(v == sel_exp(w), "R2 select readback", 64'(v), 64'(sel_exp(w)));
    end
    check_pins("R2/R3");
  endtask

  task automatic t_alt_codes();
    logic [31:0] d = '0;
    for (int k = 0; k < 8; k++) begin d[k*3 +: 3] = 3'(k); fn_exp[10 + k] = 3'(k); end
    d[24 +: 3] = 3'd2; fn_exp[18] = 3'd2;
    d[27 +: 3] = 3'd3; fn_exp[19] = 3'd3;
    wr(1, d);
    check_pins("R10 codes");
  endtask

  task automatic t_latch();
    logic [31:0] out_word = 32'h0924_9249;
    for (int w = 0; w < 6; w++) wr(w, out_word);
    for (int n = 0; n < NP; n++) fn_exp[n] = 3'd1;
    check_pins("R6 all out");
    wr(7, 32'hA5A5_0F0F); apply_lat(1, 0, 32'hA5A5_0F0F); check_pins("R4 set b0");
    wr(8, 32'hFFC0_1234); apply_lat(1, 1, 32'hFFC0_1234); check_pins("R4 set b1");
    wr(7, 32'h0000_00F0); apply_lat(1, 0, 32'h0000_00F0); check_pins("R4 zero bits keep");
    wr(10, 32'h8001_0F01); apply_lat(0, 0, 32'h8001_0F01); check_pins("R5 clr b0");
    wr(11, 32'h0020_0004); apply_lat(0, 1, 32'h0020_0004); check_pins("R5 clr b1");
  endtask

  task automatic t_oe_gate();
    wr(0, 32'h0000_0000);
    for (int n = 0; n < 10; n++) fn_exp[n] = 3'd0;
    wr(7, 32'h0000_03FF); apply_lat(1, 0, 32'h0000_03FF);
    check_pins("R6 input gates pad");
    chk(pad_out[9:0] == '0, "R6 pad low", 64'(pad_out[9:0]), 0);
  endtask

  task automatic t_zero_words();
    logic [31:0] v;
    logic [NP*3-1:0] m0 = mode;
    logic [NP-1:0] p0 = pad_out;
    int zw[9] = '{6, 7, 8, 9, 10, 11, 12, 15, 31};
    foreach (zw[i]) begin
      rd(zw[i], v);
      chk(v == '0, "R8 zero read", 64'(v), 0);
    end
    wr(6, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF); wr(20, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(mode == m0, "R8 ignored write mode", mode[63:0], m0[63:0]);
    chk(pad_out == p0, "R8 ignored write pad", 64'(pad_out), 64'(p0));
    for (int w = 0; w < 6; w++) begin
      rd(w, v);
      chk(v == sel_exp(w), "R8 select intact", 64'(v), 64'(sel_exp(w)));
    end
  endtask

  task automatic t_levels();
    logic [31:0] v;
    logic [NP-1:0] p = 54'h2A_BCDE_1234_5678;
    pad_in = p;
    repeat (2) @(negedge clk);
    rd(13, v); chk(v == p[31:0], "R7 level b0", 64'(v), 64'(p[31:0]));
    rd(14, v); chk(v == {10'd0, p[53:32]}, "R7 level b1", 64'(v), 64'({10'd0, p[53:32]}));
    @(negedge clk); addr = 5'd13;
    pad_in[31:0] = ~p[31:0];
    @(negedge clk); v = rdata; chk(v == p[31:0], "R7 edge1 old", 64'(v), 64'(p[31:0]));
    @(negedge clk); v = rdata; chk(v == p[31:0], "R7 edge2 old", 64'(v), 64'(p[31:0]));
    @(negedge clk); v = rdata; chk(v == ~p[31:0], "R7 edge3 new", 64'(v), 64'(~p[31:0]));
  endtask

  task automatic t_same_cycle();
    logic [31:0] v, old_w;
    old_w = sel_exp(2);
    @(negedge clk); addr = 5'd2; we = 1'b1; wdata = 32'h1B6D_B6DB;
    @(negedge clk); we = 1'b0; v = rdata;
    for (int k = 0; k < 10; k++) fn_exp[20 + k] = wdata[k*3 +: 3];
    chk(v == old_w, "R9 read before write", 64'(v), 64'(old_w));
    rd(2, v);
    chk(v == sel_exp(2), "R9 new value", 64'(v), 64'(sel_exp(2)));
    check_pins("R9 pins");
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_alt_codes();
    t_latch();
    t_oe_gate();
    t_zero_words();
    t_levels();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule